// File: doc/BRIEF.md
# Latency-Matched Synchronization Flag Delay

This block carries a one-cycle synchronization marker through a processing stage whose latency is long and fixed. Upstream, the marker goes high one clock before the first valid sample. Downstream, a marker must appear one clock before the first valid output sample. That output sample comes out of a stage that decimates by a fixed factor, so downstream logic samples the marker only once per decimated period. The block therefore stretches the delayed marker to one whole decimated period.

The delay is hundreds of clocks, so the block does not shift the marker through a register chain. A single loadable down counter measures the delay. The counter runs in two states. In CNT_IDLE an input marker loads LATENCY-1 and moves it to CNT_RUN. In CNT_RUN the counter decrements on each clock. A new input marker reloads LATENCY-1 and the counter stays in CNT_RUN. When the count is zero the counter raises a terminal-count signal for that cycle and returns to CNT_IDLE.

An output stage with four states turns the terminal count into the stretched flag. Every transition happens on a clock edge. With dec_en high the stage acts as follows: OUT_IDLE moves to OUT_HOLD if the terminal count is present; OUT_PEND moves to OUT_HOLD; OUT_HOLD_PEND moves to OUT_HOLD; OUT_HOLD stays in OUT_HOLD if the terminal count is present, and otherwise returns to OUT_IDLE. With dec_en low a terminal count moves OUT_IDLE to OUT_PEND and OUT_HOLD to OUT_HOLD_PEND, and every other case keeps the state. The output flag is high in OUT_HOLD and in OUT_HOLD_PEND.

Top module: `sync_flag_delay`

## Requirements
- R1: While rst_n is low, flag_out is 0. A reset also discards any delay count in progress and any pending event, so no flag_out pulse follows from a marker that arrived before the reset.
- R2: A marker sampled at clock edge t, with no later marker, produces a terminal count that is visible at edge t+LATENCY. flag_out rises at the first edge e at or after t+LATENCY at which dec_en is sampled high.
- R3: flag_out changes value only at clock edges where dec_en is sampled 1.
- R4: Once flag_out is high, it falls at the next edge where dec_en is 1, unless a new terminal count is pending at that edge. With dec_en high once every 14 clocks, flag_out is high for exactly 14 clocks.
- R5: A marker that arrives while a count is running restarts the delay from that marker. Only the last marker produces a flag_out pulse.
- R6: A terminal count that occurs while dec_en is low is remembered until the next edge with dec_en high, however long that takes.
- R7: A terminal count in the same cycle as dec_en high makes flag_out go high at that same edge.
- R8: A terminal count that occurs while flag_out is high keeps flag_out high for one more enable period after the next enable edge.
- R9: With no input marker, flag_out never rises, whatever the dec_en pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_in | input | 1 | Input synchronization marker, one cycle wide |
| dec_en | input | 1 | Decimated-phase enable, high for one cycle per output period |
| flag_out | output | 1 | Delayed marker, held for one decimated period |

## Verification
The hardest state to reach is OUT_HOLD_PEND. In that state a second terminal count arrives while the output is still held. With a regular enable every 14 clocks this cannot happen, because a restart always pushes the second terminal count past the end of the hold window. The bench therefore stops using a periodic enable in a directed case. It places single enable pulses far apart, and it sends the second marker just after the first terminal count. The second terminal count then lands inside the hold window.

// File: rtl/sync_flag_pkg.sv
package sync_flag_pkg;

    typedef enum logic {
        CNT_IDLE,
        CNT_RUN
    } cnt_state_t;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_PEND,
        OUT_HOLD,
        OUT_HOLD_PEND
    } out_state_t;

endpackage

// File: rtl/lat_down_counter.sv
module lat_down_counter
    import sync_flag_pkg::*;
#(
    parameter int LATENCY = 220
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic tc
);

    localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LATENCY - 1);

    cnt_state_t    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CNT_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            CNT_IDLE: begin
                if (start) begin
                    state_nx = CNT_RUN;
                    cnt_nx   = LOAD;
                end
            end
            CNT_RUN: begin
                if (start) begin
                    cnt_nx = LOAD;
                end else if (cnt == '0) begin
                    state_nx = CNT_IDLE;
                end else begin
                    cnt_nx = cnt - CW'(1);
                end
            end
        endcase
    end

    always_comb begin
        tc = (state == CNT_RUN) && (cnt == '0);
    end

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == LOAD) && (state == CNT_RUN));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_RUN && cnt != '0 && !start) |=> (cnt == $past(cnt) - CW'(1)));

    assert_idle_after_tc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !start) |=> (state == CNT_IDLE));

endmodule

// File: rtl/sync_flag_hold.sv
module sync_flag_hold
    import sync_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tc,
    input  logic dec_en,
    output logic flag_out
);

    out_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OUT_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_IDLE: begin
                if (tc) state_nx = dec_en ? OUT_HOLD : OUT_PEND;
            end
            OUT_PEND: begin
                if (dec_en) state_nx = OUT_HOLD;
            end
            OUT_HOLD: begin
                if (dec_en)  state_nx = tc ? OUT_HOLD : OUT_IDLE;
                else if (tc) state_nx = OUT_HOLD_PEND;
            end
            OUT_HOLD_PEND: begin
                if (dec_en) state_nx = OUT_HOLD;
            end
        endcase
    end

    always_comb begin
        flag_out = (state == OUT_HOLD) || (state == OUT_HOLD_PEND);
    end

    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> $stable(flag_out));

    assert_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && tc) |=> flag_out);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !tc && state == OUT_HOLD) |=> !flag_out);

    assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OUT_IDLE && tc && !dec_en) |=> (state == OUT_PEND));

    assert_extend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OUT_HOLD_PEND && dec_en) |=> flag_out);

endmodule

// File: rtl/sync_flag_delay.sv
module sync_flag_delay #(
    parameter int LATENCY = 220
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_in,
    input  logic dec_en,
    output logic flag_out
);

    logic tc;

    lat_down_counter #(
        .LATENCY(LATENCY)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .start (flag_in),
        .tc    (tc)
    );

    sync_flag_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc       (tc),
        .dec_en   (dec_en),
        .flag_out (flag_out)
    );

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !flag_out);

endmodule

// File: tb/sync_flag_delay_tb.sv
module sync_flag_delay_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 220;
    localparam int DECIM      = 14;
    localparam int NEDGES     = 380;
    localparam int NROWS      = 5;

    // rows: enable phase, first marker edge, second marker edge (0 = none)
    localparam int ROW_PH [NROWS] = '{0, 2, 9, 5, 13};
    localparam int ROW_P1 [NROWS] = '{5, 6, 5, 0, 40};
    localparam int ROW_P2 [NROWS] = '{0, 0, 100, 0, 0};

    logic clk = 1'b0;
    logic rst_n;
    logic flag_in;
    logic dec_en;
    logic flag_out;

    int checks = 0;
    int errors = 0;
    int edge_idx = 0;

    sync_flag_delay #(.LATENCY(LATENCY)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_in  (flag_in),
        .dec_en   (dec_en),
        .flag_out (flag_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s edge %0d actual %0d expected %0d", req, edge_idx, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic e);
        flag_in = f;
        dec_en  = e;
        @(posedge clk);
        @(negedge clk);
        edge_idx++;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        flag_in = 1'b0;
        dec_en  = 1'b0;
        repeat (3) @(negedge clk);
        chk(flag_out == 1'b0, "R1", flag_out, 0);
        rst_n    = 1'b1;
        edge_idx = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        flag_in = 1'b0;
        dec_en  = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R7 R9 with periodic enables
        for (int r = 0; r < NROWS; r++) begin
            int last;
            int rise;
            bit bad;
            int bad_edge;
            int bad_act;
            int bad_exp;
            do_reset();
            last = (ROW_P2[r] != 0) ? ROW_P2[r] : ROW_P1[r];
            rise = -1000;
            if (last != 0) begin
                rise = last + LATENCY;
                while (rise % DECIM != ROW_PH[r]) rise++;
            end
            bad = 1'b0;
            bad_edge = 0; bad_act = 0; bad_exp = 0;
            for (int e = 1; e <= NEDGES; e++) begin
                logic f;
                logic en;
                int expv;
                f  = (e == ROW_P1[r] || e == ROW_P2[r]) ? 1'b1 : 1'b0;
                en = ((e % DECIM) == ROW_PH[r]) ? 1'b1 : 1'b0;
                step(f, en);
                expv = (e >= rise && e < rise + DECIM) ? 1 : 0;
                if (int'(flag_out) != expv && !bad) begin
                    bad = 1'b1;
                    bad_edge = e; bad_act = flag_out; bad_exp = expv;
                end
            end
            edge_idx = bad_edge;
            case (r)
                0: chk(!bad, "R2/R4 single marker phase 0", bad_act, bad_exp);
                1: chk(!bad, "R7 terminal count on enable", bad_act, bad_exp);
                2: chk(!bad, "R5 restart by second marker", bad_act, bad_exp);
                3: chk(!bad, "R9 no marker no output", bad_act, bad_exp);
                default: chk(!bad, "R6/R3 latched until enable", bad_act, bad_exp);
            endcase
        end

        // Directed R8: sparse enables, second terminal count inside hold window
        do_reset();
        for (int e = 1; e <= 520; e++) begin
            logic f;
            logic en;
            f  = (e == 5 || e == 226) ? 1'b1 : 1'b0;
            en = (e == 230 || e == 500 || e == 510) ? 1'b1 : 1'b0;
            step(f, en);
            if (e == 229) chk(flag_out == 1'b0, "R6 pending not visible before enable", flag_out, 0);
            if (e == 230) chk(flag_out == 1'b1, "R6 pending loaded at enable", flag_out, 1);
            if (e == 499) chk(flag_out == 1'b1, "R3 held without enable", flag_out, 1);
            if (e == 500) chk(flag_out == 1'b1, "R8 extended by pending count", flag_out, 1);
            if (e == 509) chk(flag_out == 1'b1, "R8 held through extension", flag_out, 1);
            if (e == 510) chk(flag_out == 1'b0, "R4 cleared at following enable", flag_out, 0);
        end

        // Directed R1: reset in mid-count discards the marker
        do_reset();
        begin
            bit seen;
            seen = 1'b0;
            for (int e = 1; e <= 320; e++) begin
                logic en;
                en = ((e % DECIM) == 0) ? 1'b1 : 1'b0;
                if (e == 100) rst_n = 1'b0;
                if (e == 102) rst_n = 1'b1;
                step((e == 5) ? 1'b1 : 1'b0, en);
                if (flag_out) seen = 1'b1;
            end
            chk(!seen, "R1 reset clears running count", seen, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule